// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block watches two reference clocks, a primary and a backup, and decides which of them feeds a downstream clock consumer. It runs entirely on a free-running monitor clock. Both references are brought into that domain through synchronizers and their rising edges are counted over fixed windows. A reference that shows too few edges in a window is flagged bad. A selection state machine then moves the select output between the references according to a static two-bit mode input. The mode can be automatic failover, manual toggling from an external switch input, or automatic failover that a held switch input blocks. An optional generator sends a fixed-width reset pulse to the PLL each time its lock input falls.

The glitch-free clock multiplexer and the PLL are outside the block. The select output is a plain level meant to drive such a multiplexer. The lock input is treated as an asynchronous level.

The selection machine has four states. S_ON_PRI and S_ON_BAK are the settled states. S_HAND_TO_BAK and S_HAND_TO_PRI are one-cycle handoff states. A switch request in a settled state (`go`) moves the machine into the matching handoff state, and the handoff state always passes to the opposite settled state on the next cycle. Requests that arrive during a handoff cycle are dropped. The switch qualifier has three states. In Q_WAIT_HIGH it waits for the synchronized switch input to be seen high. Q_ARMED moves to Q_LOW on a low level. Q_LOW counts low cycles: it returns to Q_ARMED if the input goes high again, and it fires a one-cycle pulse and returns to Q_WAIT_HIGH once the input has been low for LOW_MIN cycles.

Top module: `refclk_switch_ctrl`

## Requirements
- R1: After reset, sel_backup, bad_pri, bad_bak and pll_rst are all 0.
- R2: Each reference has its own flag. The flag goes to 1 at the end of a WIN_CYC-cycle window in which fewer than MIN_EDGES synchronized rising edges of that reference were seen. It returns to 0 at the end of the first complete window that holds at least MIN_EDGES edges.
- R3: A running reference is not flagged when the two reference periods differ by up to 20 percent, as long as each period yields at least MIN_EDGES edges per window.
- R4: sel_backup is 0 while the primary reference is selected and 1 while the backup is selected.
- R5: In mode 0 (automatic), when the selected reference is flagged bad and the other is not, the selection moves to the other reference. It stays there after the failed reference recovers.
- R6: In the automatic modes, the selection never moves to a reference that is flagged bad. When both references are bad, the selection is held.
- R7: In mode 1 (manual), the selection toggles once for each high-to-low transition of ext_sw that is followed by at least LOW_MIN consecutive low cycles, counted after synchronization. A shorter low pulse has no effect, and a loss of a reference causes no switch.
- R8: In mode 2 (automatic with override), no switch happens while ext_sw is held high. With ext_sw low, this mode behaves as mode 0. Mode value 3 holds the selection.
- R9: With AUTO_RST=1, each falling edge of pll_locked produces exactly one pll_rst pulse that lasts RST_W monitor cycles. A rising edge produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Active-low reset |
| ref_pri | input | 1 | Primary reference clock, sampled as data |
| ref_bak | input | 1 | Backup reference clock, sampled as data |
| mode | input | 2 | 0 automatic, 1 manual, 2 automatic with override, 3 hold |
| ext_sw | input | 1 | External switch / override control, asynchronous |
| pll_locked | input | 1 | PLL lock indication, asynchronous |
| sel_backup | output | 1 | Active reference: 0 primary, 1 backup |
| bad_pri | output | 1 | Primary reference flagged as stopped |
| bad_bak | output | 1 | Backup reference flagged as stopped |
| pll_rst | output | 1 | Auto-reset pulse to the PLL |

## Verification
The bench builds the block with WIN_CYC=32, MIN_EDGES=3, LOW_MIN=3, RST_W=5 and AUTO_RST=1. The short window lets loss and recovery settle within about a hundred cycles, so many stop, restart and dual-loss scenarios fit in one run. Random reference half-periods of 2 to 4 cycles stay close to the edge threshold, which tests the tolerance to unequal periods. Random low-pulse widths of 1 to 6 cycles on ext_sw fall on both sides of the three-cycle qualification limit.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO     = 2'd0,
        MODE_MANUAL   = 2'd1,
        MODE_AUTO_OVR = 2'd2,
        MODE_HOLD     = 2'd3
    } sw_mode_e;

    typedef enum logic [1:0] {
        S_ON_PRI,
        S_HAND_TO_BAK,
        S_ON_BAK,
        S_HAND_TO_PRI
    } sel_state_e;

    typedef enum logic [1:0] {
        Q_WAIT_HIGH,
        Q_ARMED,
        Q_LOW
    } qual_state_e;

endpackage

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
    parameter int WIN_CYC   = 256,
    parameter int MIN_EDGES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic bad
);
    localparam int CW = $clog2(WIN_CYC);
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYC - 1);
    localparam logic [EW-1:0] MIN_V    = EW'(MIN_EDGES);

    logic [2:0]    sync_q;
    logic          rise;
    logic [CW-1:0] win_cnt;
    logic          win_end;
    logic [EW-1:0] edge_cnt;
    logic          enough;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ref_in};
    end

    assign rise    = sync_q[1] & ~sync_q[2];
    assign win_end = (win_cnt == WIN_LAST);
    assign enough  = (edge_cnt == MIN_V) || (rise && (edge_cnt == MIN_V - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            bad      <= 1'b0;
        end else begin
            win_cnt <= win_end ? '0 : win_cnt + 1'b1;
            if (win_end) begin
                edge_cnt <= '0;
                bad      <= !enough;
            end else if (rise && edge_cnt != MIN_V) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    // R2
    bad_only_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(bad));

endmodule

// File: rtl/sw_qualifier.sv
module sw_qualifier
    import refsw_pkg::*;
#(
    parameter int LOW_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sw,
    output logic ext_lvl,
    output logic fire
);
    localparam int LW = $clog2(LOW_MIN + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(LOW_MIN - 1);

    logic [1:0]    sync_q;
    qual_state_e   state, state_nx;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], ext_sw};
    end
    assign ext_lvl = sync_q[1];

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_WAIT_HIGH: if (ext_lvl) state_nx = Q_ARMED;
            Q_ARMED:     if (!ext_lvl) state_nx = Q_LOW;
            Q_LOW: begin
                if (ext_lvl)                   state_nx = Q_ARMED;
                else if (low_cnt == LOW_LAST)  state_nx = Q_WAIT_HIGH;
            end
            default:     state_nx = Q_WAIT_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= Q_WAIT_HIGH;
            low_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == Q_ARMED)     low_cnt <= LW'(1);
            else if (state == Q_LOW)  low_cnt <= low_cnt + 1'b1;
        end
    end

    always_comb begin
        fire = (state == Q_LOW) && !ext_lvl && (low_cnt == LOW_LAST);
    end

    // R7
    fire_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !ext_lvl && $past(!ext_lvl));

endmodule

// File: rtl/sel_fsm.sv
module sel_fsm
    import refsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ext_lvl,
    input  logic       fire,
    input  logic       bad_pri,
    input  logic       bad_bak,
    output logic       sel_backup
);
    sel_state_e state, state_nx;
    logic cur_bad, oth_bad, auto_ok, go;

    always_comb begin
        cur_bad = (state == S_ON_BAK) ? bad_bak : bad_pri;
        oth_bad = (state == S_ON_BAK) ? bad_pri : bad_bak;
        auto_ok = (mode == MODE_AUTO) || (mode == MODE_AUTO_OVR && !ext_lvl);
        go      = ((mode == MODE_MANUAL) && fire) || (auto_ok && cur_bad && !oth_bad);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_ON_PRI:      if (go) state_nx = S_HAND_TO_BAK;
            S_HAND_TO_BAK: state_nx = S_ON_BAK;
            S_ON_BAK:      if (go) state_nx = S_HAND_TO_PRI;
            S_HAND_TO_PRI: state_nx = S_ON_PRI;
            default:       state_nx = S_ON_PRI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_ON_PRI;
        else        state <= state_nx;
    end

    always_comb begin
        sel_backup = (state == S_HAND_TO_BAK) || (state == S_ON_BAK);
    end

    // R6
    no_bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel_backup) && $past(mode) != MODE_MANUAL) |-> !$past(bad_bak));

    // R8
    override_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO_OVR && ext_lvl) |=> $stable(sel_backup));

    // R7
    manual_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_MANUAL && sel_backup != $past(sel_backup)) |-> $past(fire));

endmodule

// File: rtl/auto_rst_gen.sv
module auto_rst_gen #(
    parameter int RST_W    = 16,
    parameter bit AUTO_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic locked,
    output logic pll_rst
);
    localparam int RW = $clog2(RST_W + 1);

    logic [2:0] sync_q;
    logic       fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], locked};
    end
    assign fall = sync_q[2] & ~sync_q[1];

    generate
        if (AUTO_RST) begin : g_on
            logic [RW-1:0] left_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             left_q <= '0;
                else if (fall)          left_q <= RW'(RST_W);
                else if (left_q != '0)  left_q <= left_q - 1'b1;
            end
            assign pll_rst = (left_q != '0);
        end else begin : g_off
            assign pll_rst = 1'b0;
        end
    endgenerate

    // R9
    rst_from_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_rst) |-> $past(fall));

endmodule

// File: rtl/refclk_switch_ctrl.sv
module refclk_switch_ctrl #(
    parameter int WIN_CYC   = 256,
    parameter int MIN_EDGES = 8,
    parameter int LOW_MIN   = 3,
    parameter int RST_W     = 16,
    parameter bit AUTO_RST  = 1'b1
) (
    input  logic       mon_clk,
    input  logic       rst_n,
    input  logic       ref_pri,
    input  logic       ref_bak,
    input  logic [1:0] mode,
    input  logic       ext_sw,
    input  logic       pll_locked,
    output logic       sel_backup,
    output logic       bad_pri,
    output logic       bad_bak,
    output logic       pll_rst
);
    localparam int NREF = 2;

    logic [NREF-1:0] refs, bads;
    logic ext_lvl, fire;

    assign refs    = {ref_bak, ref_pri};
    assign bad_pri = bads[0];
    assign bad_bak = bads[1];

    generate
        for (genvar i = 0; i < NREF; i++) begin : g_mon
            clk_loss_mon #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_mon (
                .clk(mon_clk), .rst_n(rst_n), .ref_in(refs[i]), .bad(bads[i])
            );
        end
    endgenerate

    sw_qualifier #(.LOW_MIN(LOW_MIN)) u_qual (
        .clk(mon_clk), .rst_n(rst_n), .ext_sw(ext_sw), .ext_lvl(ext_lvl), .fire(fire)
    );

    sel_fsm u_fsm (
        .clk(mon_clk), .rst_n(rst_n), .mode(mode), .ext_lvl(ext_lvl), .fire(fire),
        .bad_pri(bads[0]), .bad_bak(bads[1]), .sel_backup(sel_backup)
    );

    auto_rst_gen #(.RST_W(RST_W), .AUTO_RST(AUTO_RST)) u_arst (
        .clk(mon_clk), .rst_n(rst_n), .locked(pll_locked), .pll_rst(pll_rst)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge mon_clk)
        !rst_n |=> (!sel_backup && !bad_pri && !bad_bak && !pll_rst));

endmodule

// File: tb/refclk_switch_ctrl_tb.sv
module refclk_switch_ctrl_tb_top;
    localparam int WIN = 32;
    localparam int MINE = 3;
    localparam int LOWM = 3;
    localparam int RSTW = 5;
    localparam int SETTLE = 3 * WIN + 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_a = 1'b0, ref_b = 1'b0, run_a = 1'b0, run_b = 1'b0;
    int   ha = 2, hb = 2, ca = 0, cb = 0;
    logic [1:0] mode = 2'd0;
    logic ext_sw = 1'b1, locked = 1'b1;
    logic sel, bad_a, bad_b, prst;
    int vectors = 0, fails = 0;
    logic exp_sel = 1'b0;

    always #2 clk = ~clk;

    refclk_switch_ctrl #(.WIN_CYC(WIN), .MIN_EDGES(MINE), .LOW_MIN(LOWM),
                         .RST_W(RSTW), .AUTO_RST(1'b1)) dut_i (
        .mon_clk(clk), .rst_n(rst_n), .ref_pri(ref_a), .ref_bak(ref_b),
        .mode(mode), .ext_sw(ext_sw), .pll_locked(locked),
        .sel_backup(sel), .bad_pri(bad_a), .bad_bak(bad_b), .pll_rst(prst)
    );

    always @(negedge clk) begin
        if (run_a) begin
            if (ca >= ha - 1) begin ref_a <= ~ref_a; ca <= 0; end
            else ca <= ca + 1;
        end
        if (run_b) begin
            if (cb >= hb - 1) begin ref_b <= ~ref_b; cb <= 0; end
            else cb <= cb + 1;
        end
    end

    function automatic logic manual_toggles(int low_len);
        return low_len >= LOWM;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic status(string req, logic ea, logic eb);
        chk({req, " sel"}, sel, exp_sel);
        chk({req, " bad_pri"}, bad_a, ea);
        chk({req, " bad_bak"}, bad_b, eb);
    endtask

    task automatic count_rst(output int n);
        n = 0;
        repeat (30) begin @(negedge clk); if (prst) n++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n;
        logic ts;
        void'($urandom(32'd4711));
        cyc(3);
        // R1 reset state
        chk("R1 sel", sel, 0); chk("R1 bad_pri", bad_a, 0);
        chk("R1 bad_bak", bad_b, 0); chk("R1 pll_rst", prst, 0);
        rst_n = 1'b1;
        run_a = 1'b1; run_b = 1'b1;
        cyc(SETTLE);
        // R3 random period mixes within tolerance
        for (int t = 0; t < 6; t++) begin
            ha = $urandom_range(4, 2); hb = $urandom_range(4, 2);
            cyc(SETTLE);
            status("R3 random periods", 0, 0);
        end
        ha = 3; hb = 2;
        // R5 R2 R4 primary stops, failover to backup
        run_a = 1'b0; cyc(SETTLE); exp_sel = 1'b1;
        status("R5 failover to backup", 1, 0);
        chk("R4 active shows backup", sel, 1);
        run_a = 1'b1; cyc(SETTLE);
        status("R5 stays after recovery", 0, 0);
        run_b = 1'b0; cyc(SETTLE); exp_sel = 1'b0;
        status("R5 failover to primary", 0, 1);
        chk("R4 active shows primary", sel, 0);
        run_b = 1'b1; cyc(SETTLE);
        status("R2 flag clears", 0, 0);
        // R6 both lost: hold
        run_b = 1'b0; cyc(SETTLE);
        status("R6 backup lost, no switch", 0, 1);
        run_a = 1'b0; cyc(SETTLE);
        status("R6 both lost hold", 1, 1);
        run_a = 1'b1; run_b = 1'b1; cyc(SETTLE);
        status("R6 both recover", 0, 0);
        // R8 override blocks while ext_sw high
        mode = 2'd2; ext_sw = 1'b1; cyc(10);
        run_a = 1'b0; cyc(SETTLE);
        status("R8 override held", 1, 0);
        ext_sw = 1'b0; cyc(10); exp_sel = 1'b1;
        status("R8 override released", 1, 0);
        run_a = 1'b1; cyc(SETTLE);
        status("R8 recovered", 0, 0);
        // R7 manual mode
        ext_sw = 1'b1; mode = 2'd1; cyc(10);
        ext_sw = 1'b0; cyc(2); ext_sw = 1'b1; cyc(10);
        status("R7 short low ignored", 0, 0);
        ext_sw = 1'b0; cyc(8); ext_sw = 1'b1; cyc(10); exp_sel = ~exp_sel;
        status("R7 qualified low toggles", 0, 0);
        for (int t = 0; t < 8; t++) begin
            n = $urandom_range(6, 1);
            ext_sw = 1'b0; cyc(n); ext_sw = 1'b1; cyc(10);
            if (manual_toggles(n)) exp_sel = ~exp_sel;
            status("R7 random low width", 0, 0);
        end
        ts = exp_sel;
        if (ts) run_b = 1'b0; else run_a = 1'b0;
        cyc(SETTLE);
        status("R7 loss causes no switch", !ts, ts);
        run_a = 1'b1; run_b = 1'b1; cyc(SETTLE);
        // R9 auto reset pulse
        locked = 1'b0; count_rst(n);
        chk("R9 pulse width on lock loss", n, RSTW);
        locked = 1'b1; count_rst(n);
        chk("R9 no pulse on lock gain", n, 0);
        locked = 1'b0; count_rst(n);
        chk("R9 second loss pulse", n, RSTW);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule